// File: doc/BRIEF.md
# Watchdog Timer/Counter with Reset Generator

This block is a 16-bit up-counter that can serve as an interval timer, an event counter or a watchdog. A select input chooses the count source. In one setting the count advances once per machine cycle, which is 12 clock periods. In the other it advances once per falling edge of an external input. That input is synchronised and then compared between successive machine-cycle samples.

Software sets the count one byte at a time and clears the overflow flag. With the watchdog enable low, an overflow raises an interrupt request. With it high, the overflow starts a reset pulse of fixed length in the next machine cycle. During that pulse a companion output tells data memory to keep its contents.

A power-down input stops the internal machine-cycle count. Counting from the external input still runs, so the watchdog can still fire while the device sleeps.

Top module: `wdog_tc`

## Requirements
- R1: With `ext_sel`=0 and `pwr_down`=0, `count_o` rises by exactly 1 every 12 clock cycles.
- R2: With `ext_sel`=1, `count_o` rises by exactly 1 for each falling edge of `ext_in`, provided the input stays high for at least 24 clocks and low for at least 24 clocks.
- R3: With `pwr_down`=1 and `ext_sel`=0, `count_o` does not change. With `pwr_down`=1 and `ext_sel`=1, external edges are still counted.
- R4: A clock edge with `wr_hi`=1 loads `wr_data` into `count_o[15:8]`, and one with `wr_lo`=1 loads it into `count_o[7:0]`. A write wins over an increment that falls on the same edge.
- R5: When the count steps from 16'hFFFF, `count_o` becomes 0 and `ovf_flag` goes to 1 on the same edge. The flag then stays at 1 until `flag_clr` is pulsed.
- R6: `irq` is 1 exactly while `ovf_flag`=1 and `wd_en`=0. With `wd_en`=1, `irq` stays 0 after an overflow.
- R7: With `wd_en`=1, `wd_rst` rises 12 clocks after the overflow edge, which is the next machine cycle. It stays at 1 for 60 clocks (5 machine cycles).
- R8: While `wd_rst`=1, `count_o` is held at 0, `ovf_flag` is 0 and writes are ignored. The pulse is neither restarted nor lengthened.
- R9: `mem_keep` is 1 exactly during the watchdog reset pulse.
- R10: With `pwr_down`=1, `ext_sel`=1 and `wd_en`=1, an overflow driven by `ext_in` still produces the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ext_sel | input | 1 | 0 counts machine cycles, 1 counts external falling edges |
| pwr_down | input | 1 | Stops the internal machine-cycle count |
| wd_en | input | 1 | 1 makes overflow trigger the reset pulse |
| ext_in | input | 1 | Asynchronous external event input |
| wr_hi | input | 1 | Load `wr_data` into the upper count byte |
| wr_lo | input | 1 | Load `wr_data` into the lower count byte |
| wr_data | input | 8 | Byte written by software |
| flag_clr | input | 1 | Clears the overflow flag |
| count_o | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request from overflow |
| wd_rst | output | 1 | Watchdog system reset pulse |
| mem_keep | output | 1 | Tells data memory not to initialise |

## Verification
The bench times every check from the clock edge that caused the result. Count, flag and byte writes appear on the edge they act on. `wd_rst` rises exactly 12 edges after the edge on which `ovf_flag` rises, and falls 60 edges after that. An external falling edge is counted up to 14 clocks after it occurs. Because the machine-cycle phase is not visible, the bench first detects a count step or a flag rise and counts edges from there. It samples on falling clock edges, and checks on external counts wait well beyond the 14-clock bound.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_DIV    = 12;
    localparam int unsigned DEF_RST_MC = 5;
    localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = (pre_q == LAST) ? '0 : pre_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
endmodule

// File: rtl/wdog_extsync.sv
module wdog_extsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ext_in,
    output logic evt
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              smp_d, smp_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                assign sync_d[i] = ext_in;
            end else begin : g_next
                assign sync_d[i] = sync_q[i-1];
            end
        end
    endgenerate

    always_comb begin
        smp_d = tick ? sync_q[STAGES-1] : smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            smp_q  <= 1'b0;
        end else begin
            sync_q <= sync_d;
            smp_q  <= smp_d;
        end
    end

    assign evt = tick & smp_q & ~sync_q[STAGES-1];

    AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> tick); // R2
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R2
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV    = 12,
    parameter int unsigned RST_MC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             wd_en,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             pulse
);
    localparam int unsigned LO_W = 8;
    localparam int unsigned HI_W = CNT_W - LO_W;
    localparam int unsigned LW   = (RST_MC > 1) ? $clog2(RST_MC) : 1;
    localparam int unsigned PULSE_CLK = RST_MC * DIV;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
        wd_state_e        state;
        logic [LW-1:0]    left;
    } core_s;

    core_s st_d, st_q;
    logic  ovf, start, hold_rst, wr_any;

    always_comb begin
        st_d     = st_q;
        wr_any   = wr_hi | wr_lo;
        ovf      = cnt_en && !wr_any && (st_q.count == '1) && (st_q.state != WD_PULSE);
        start    = (st_q.state == WD_ARMED) && tick;
        hold_rst = (st_q.state == WD_PULSE) || start;

        if (hold_rst) begin
            st_d.count = '0;
            st_d.flag  = 1'b0;
        end else begin
            if (wr_any) begin
                if (wr_hi) st_d.count[CNT_W-1:LO_W] = HI_W'(wr_data);
                if (wr_lo) st_d.count[LO_W-1:0]     = wr_data;
            end else if (cnt_en) begin
                st_d.count = st_q.count + CNT_W'(1);
            end
            if (ovf)           st_d.flag = 1'b1;
            else if (flag_clr) st_d.flag = 1'b0;
        end

        unique case (st_q.state)
            WD_IDLE: begin
                if (ovf && wd_en) st_d.state = WD_ARMED;
            end
            WD_ARMED: begin
                if (tick) begin
                    st_d.state = WD_PULSE;
                    st_d.left  = LW'(RST_MC - 1);
                end
            end
            WD_PULSE: begin
                if (tick) begin
                    if (st_q.left == '0) st_d.state = WD_IDLE;
                    else                 st_d.left  = st_q.left - LW'(1);
                end
            end
            default: st_d.state = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '0;
            st_q.flag  <= 1'b0;
            st_q.state <= WD_IDLE;
            st_q.left  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign flag  = st_q.flag;
    assign pulse = (st_q.state == WD_PULSE);

    // Clock count of the current reset pulse, used only by the checks below
    logic [15:0] plen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     plen_q <= '0;
        else if (pulse) plen_q <= plen_q + 16'd1;
        else            plen_q <= '0;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_any && !hold_rst) |=> (count == $past(count) + CNT_W'(1))); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_any && !hold_rst) |=> $stable(count)); // R3
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_any && !hold_rst && count == '1) |=> (flag && count == '0)); // R5
    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(tick)); // R7
    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!flag && count == '0)); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> (plen_q == 16'(PULSE_CLK))); // R8
endmodule

// File: rtl/wdog_tc.sv
module wdog_tc
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned DIV    = DEF_DIV,
    parameter int unsigned RST_MC = DEF_RST_MC,
    parameter int unsigned SYNC   = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             pwr_down,
    input  logic             wd_en,
    input  logic             ext_in,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wd_rst,
    output logic             mem_keep
);
    logic tick, evt, cnt_en, pulse;

    wdog_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    wdog_extsync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ext_in(ext_in),
        .evt   (evt)
    );

    assign cnt_en = ext_sel ? evt : (tick & ~pwr_down);

    wdog_core #(.CNT_W(CNT_W), .DIV(DIV), .RST_MC(RST_MC)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_en  (cnt_en),
        .wd_en   (wd_en),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .flag_clr(flag_clr),
        .count   (count_o),
        .flag    (ovf_flag),
        .pulse   (pulse)
    );

    assign irq      = ovf_flag & ~wd_en;
    assign wd_rst   = pulse;
    assign mem_keep = pulse;

    AST_PD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !ext_sel && !wr_hi && !wr_lo && !wd_rst && !$rose(wd_rst)) |=> (count_o == $past(count_o) || wd_rst)); // R3
endmodule

// File: tb/tb_wdog_tc.sv
module tb_wdog_tc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_sel = 1'b0, pwr_down = 1'b0, wd_en = 1'b0, ext_in = 1'b0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0, flag_clr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] count_o;
    logic        ovf_flag, irq, wd_rst, mem_keep;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_tc dut (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .pwr_down(pwr_down),
        .wd_en(wd_en), .ext_in(ext_in), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .flag_clr(flag_clr), .count_o(count_o),
        .ovf_flag(ovf_flag), .irq(irq), .wd_rst(wd_rst), .mem_keep(mem_keep)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write16(input logic [15:0] v);
        @(negedge clk); wr_hi = 1'b1; wr_data = v[15:8];
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0];
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_in = 1'b1; repeat (24) @(negedge clk);
        ext_in = 1'b0; repeat (24) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R5", "count after reset", count_o, 0);
        chk("R5", "flag after reset", ovf_flag, 0);
        chk("R6", "irq after reset", irq, 0);
        chk("R9", "rst/keep after reset", {wd_rst, mem_keep}, 0);
    endtask

    task automatic t_internal();
        logic [15:0] v;
        ext_sel = 1'b0; pwr_down = 1'b1;
        write16(16'h12F0);
        chk("R4", "two-byte write", count_o, 16'h12F0);
        pwr_down = 1'b0;
        @(negedge clk); v = count_o;
        repeat (12) @(negedge clk);
        chk("R1", "one step per 12 clocks", count_o, v + 16'd1);
        repeat (24) @(negedge clk);
        chk("R1", "three steps per 36 clocks", count_o, v + 16'd3);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        v = count_o;
        for (int i = 0; i < 20 && count_o == v; i++) @(negedge clk);
        repeat (11) @(negedge clk);
        wr_lo = 1'b1; wr_data = 8'h77;
        @(negedge clk); wr_lo = 1'b0;
        chk("R4", "write beats same-edge tick", count_o[7:0], 8'h77);
        repeat (12) @(negedge clk);
        chk("R4", "count resumes after write", count_o[7:0], 8'h78);
    endtask

    task automatic t_powerdown();
        logic [15:0] v;
        ext_sel = 1'b0; pwr_down = 1'b1;
        @(negedge clk); v = count_o;
        repeat (50) @(negedge clk);
        chk("R3", "internal count frozen", count_o, v);
    endtask

    task automatic t_external();
        logic [15:0] v;
        ext_sel = 1'b1; pwr_down = 1'b1; ext_in = 1'b0;
        write16(16'h0100);
        v = count_o;
        repeat (3) ext_pulse();
        repeat (20) @(negedge clk);
        chk("R2", "three falling edges counted", count_o, v + 16'd3);
        chk("R3", "external count runs in power-down", count_o, 16'h0103);
    endtask

    task automatic t_irq();
        ext_sel = 1'b0; pwr_down = 1'b1; wd_en = 1'b0;
        write16(16'hFFFF);
        chk("R5", "no flag before wrap", ovf_flag, 0);
        pwr_down = 1'b0;
        for (int i = 0; i < 20 && !ovf_flag; i++) @(negedge clk);
        chk("R5", "flag on wrap", ovf_flag, 1);
        chk("R5", "count wraps to 0", count_o, 0);
        chk("R6", "irq with watchdog off", irq, 1);
        repeat (30) @(negedge clk);
        chk("R5", "flag sticky", ovf_flag, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R5", "flag cleared by software", ovf_flag, 0);
        chk("R6", "irq drops with flag", irq, 0);
    endtask

    task automatic t_watchdog();
        ext_sel = 1'b0; pwr_down = 1'b1; wd_en = 1'b1;
        write16(16'hFFFF);
        pwr_down = 1'b0;
        for (int i = 0; i < 20 && !ovf_flag; i++) @(negedge clk);
        chk("R5", "flag on watchdog wrap", ovf_flag, 1);
        chk("R6", "no irq in watchdog mode", irq, 0);
        chk("R7", "no reset on overflow edge", wd_rst, 0);
        repeat (11) @(negedge clk);
        chk("R7", "reset still low at +11", wd_rst, 0);
        @(negedge clk);
        chk("R7", "reset high at +12", wd_rst, 1);
        chk("R9", "mem_keep high in pulse", mem_keep, 1);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h55;
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
        repeat (27) @(negedge clk);
        chk("R8", "flag cleared in pulse", ovf_flag, 0);
        chk("R8", "count held 0, write ignored", count_o, 0);
        repeat (31) @(negedge clk);
        chk("R7", "reset high at +71", wd_rst, 1);
        @(negedge clk);
        chk("R7", "reset low at +72", wd_rst, 0);
        chk("R9", "mem_keep low after pulse", mem_keep, 0);
        chk("R8", "count 0 at pulse end", count_o, 0);
        wd_en = 1'b0;
    endtask

    task automatic t_pd_watchdog();
        ext_sel = 1'b1; pwr_down = 1'b1; wd_en = 1'b1; ext_in = 1'b0;
        write16(16'hFFFF);
        ext_pulse();
        for (int i = 0; i < 100 && !wd_rst; i++) @(negedge clk);
        chk("R10", "reset from external wrap in power-down", wd_rst, 1);
        chk("R9", "mem_keep in power-down pulse", mem_keep, 1);
        for (int i = 0; i < 80 && wd_rst; i++) @(negedge clk);
        chk("R10", "pulse ends", wd_rst, 0);
        chk("R8", "count 0 after pulse", count_o, 0);
        wd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_internal();
        t_priority();
        t_powerdown();
        t_external();
        t_irq();
        t_watchdog();
        t_pd_watchdog();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule